// File: doc/BRIEF.md
# GPIO Port with Per-Line Interrupts

This block is a general-purpose I/O port of up to 32 lines, controlled through a small APB-style register bus. Each line has a direction bit and an output value bit. Every pin input is sampled through a two-stage synchroniser. Lines built with interrupt support each drive their own interrupt output. For each of those lines, software chooses edge or level triggering, chooses the active polarity, and gates the interrupt with a mask bit. A bypass register hands a pin to an alternate core's output value and output enable.

The line count and the set of interrupt-capable lines are fixed by parameters. Software can still discover both at run time. Output register bits above the line count are not stored. Polarity bits of lines without interrupt support cannot be written. Writing all ones to either register and reading it back shows which lines exist and which can interrupt.

The bus front end is a three-state machine. It starts in `BUS_IDLE`. A setup phase (select high, enable low) moves it to `BUS_ARMED`, and it stays there while further setup phases arrive. An access phase seen in `BUS_ARMED` completes the transfer and moves it to `BUS_DONE`. From `BUS_DONE` a new setup phase returns it to `BUS_ARMED`; anything else returns it to `BUS_IDLE`. From `BUS_ARMED` a cycle with select low also returns it to `BUS_IDLE`. Only an access phase taken in `BUS_ARMED` reads or writes a register.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, all stored registers (output, direction, mask, polarity, edge, bypass) read 0, every `pin_oe` is 0 and every `irq` is 0.
- R2: The word address `paddr` selects the register: 0 sampled input data, 1 output value, 2 direction, 3 interrupt mask, 4 polarity, 5 edge select, 6 bypass. Address 7 reads 0. Bit n of every register belongs to line n. Read data is valid in the access phase with no wait states.
- R3: With bypass bit n at 0, `pin_oe[n]` equals direction bit n (1 = output) and `pin_out[n]` equals output bit n.
- R4: Output register bits at or above `NUM_LINES` are not stored and read 0.
- R5: Polarity bits of lines whose bit in `IRQ_LINES` is 0 cannot be written and read 0.
- R6: The data register returns each pin's level as seen through two synchroniser flops: a pin change made before clock edge k is visible from edge k+1.
- R7: With edge bit n at 0 (level mode), `irq[n]` is high while mask bit n is 1 and the synchronised level equals polarity bit n (1 = high, 0 = low).
- R8: With edge bit n at 1, `irq[n]` pulses for exactly one cycle when the synchronised value changes toward the polarity (1 = rising, 0 = falling) and mask bit n is 1.
- R9: `irq[n]` stays 0 while mask bit n is 0, and it is always 0 for a line without interrupt support.
- R10: With bypass bit n at 1, `pin_out[n]` follows `alt_out[n]` and `pin_oe[n]` follows `alt_oe[n]`.
- R11: A register write takes effect only in an access phase that follows a setup phase. An enable without a preceding setup, or a transfer with `psel` low, leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and port clock |
| presetn | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Block select |
| penable | input | 1 | Access-phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 3 | Word address (byte address bits 4:2) |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pin_in | input | NUM_LINES | Raw pin levels |
| alt_out | input | NUM_LINES | Alternate core output values |
| alt_oe | input | NUM_LINES | Alternate core output enables |
| pin_out | output | NUM_LINES | Pin output values |
| pin_oe | output | NUM_LINES | Pin output enables |
| irq | output | NUM_LINES | Per-line interrupt outputs |

## Verification
A wrong internal state shows at the ports within one or two cycles of the stimulus that exposes it. A bad direction, output or bypass bit changes `pin_oe` or `pin_out` on the cycle after the write. A stale or missing synchroniser stage moves the rise of `irq` by a cycle. A lost previous-value register turns an edge pulse into a level or drops it. A bus state machine that accepts a transfer without a setup phase shows up as a changed register on the next readback. The bench compares all pin and interrupt outputs on every cycle against a behavioural model, so each of these faults is reported on the cycle it first appears.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    // Word offsets of the registers (bit n of each belongs to line n)
    typedef enum logic [2:0] {
        OFS_DATA = 3'd0,
        OFS_OUT  = 3'd1,
        OFS_DIR  = 3'd2,
        OFS_MASK = 3'd3,
        OFS_POL  = 3'd4,
        OFS_EDGE = 3'd5,
        OFS_BYP  = 3'd6
    } reg_ofs_e;

    // Bus transfer phases
    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_ARMED = 2'd1,
        BUS_DONE  = 2'd2
    } bus_state_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_in,
    output logic [WIDTH-1:0] synced
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= raw_in;
            stage2_q <= stage1_q;
        end
    end

    assign synced = stage2_q;
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_irq_pkg::*;
#(
    parameter int          NUM_LINES = 32,
    parameter logic [31:0] IRQ_LINES = 32'hFFFF_FFFF
) (
    input  logic                 pclk,
    input  logic                 presetn,
    input  logic                 psel,
    input  logic                 penable,
    input  logic                 pwrite,
    input  logic [2:0]           paddr,
    input  logic [31:0]          pwdata,
    output logic [31:0]          prdata,
    input  logic [NUM_LINES-1:0] data_in,
    output logic [NUM_LINES-1:0] out_q,
    output logic [NUM_LINES-1:0] dir_q,
    output logic [NUM_LINES-1:0] mask_q,
    output logic [NUM_LINES-1:0] pol_q,
    output logic [NUM_LINES-1:0] edge_q,
    output logic [NUM_LINES-1:0] byp_q
);
    localparam logic [NUM_LINES-1:0] CAP_MASK = IRQ_LINES[NUM_LINES-1:0];

    bus_state_e state_q, state_d;
    logic       access_ok;
    logic       wr_en;

    // State register
    always_ff @(posedge pclk) begin
        if (!presetn) state_q <= BUS_IDLE;
        else          state_q <= state_d;
    end

    // Next state and phase outputs
    always_comb begin
        state_d   = state_q;
        access_ok = 1'b0;
        unique case (state_q)
            BUS_IDLE: begin
                if (psel && !penable) state_d = BUS_ARMED;
            end
            BUS_ARMED: begin
                if (psel && penable) begin
                    access_ok = 1'b1;
                    state_d   = BUS_DONE;
                end else if (!psel) begin
                    state_d = BUS_IDLE;
                end
            end
            BUS_DONE: begin
                if (psel && !penable) state_d = BUS_ARMED;
                else                  state_d = BUS_IDLE;
            end
            default: state_d = BUS_IDLE;
        endcase
    end

    assign wr_en = access_ok && pwrite;

    always_ff @(posedge pclk) begin
        if (!presetn) begin
            out_q  <= '0;
            dir_q  <= '0;
            mask_q <= '0;
            pol_q  <= '0;
            edge_q <= '0;
            byp_q  <= '0;
        end else if (wr_en) begin
            case (paddr)
                OFS_OUT:  out_q  <= pwdata[NUM_LINES-1:0];
                OFS_DIR:  dir_q  <= pwdata[NUM_LINES-1:0];
                OFS_MASK: mask_q <= pwdata[NUM_LINES-1:0];
                OFS_POL:  pol_q  <= pwdata[NUM_LINES-1:0] & CAP_MASK;
                OFS_EDGE: edge_q <= pwdata[NUM_LINES-1:0];
                OFS_BYP:  byp_q  <= pwdata[NUM_LINES-1:0];
                default:  ;
            endcase
        end
    end

    always_comb begin
        prdata = '0;
        if (access_ok && !pwrite) begin
            case (paddr)
                OFS_DATA: prdata[NUM_LINES-1:0] = data_in;
                OFS_OUT:  prdata[NUM_LINES-1:0] = out_q;
                OFS_DIR:  prdata[NUM_LINES-1:0] = dir_q;
                OFS_MASK: prdata[NUM_LINES-1:0] = mask_q;
                OFS_POL:  prdata[NUM_LINES-1:0] = pol_q;
                OFS_EDGE: prdata[NUM_LINES-1:0] = edge_q;
                OFS_BYP:  prdata[NUM_LINES-1:0] = byp_q;
                default:  prdata = '0;
            endcase
        end
    end

    // R11
    naked_access_chk: assert property (@(posedge pclk) disable iff (!presetn)
        (state_q == BUS_IDLE && psel && penable)
        |=> ($stable(out_q) && $stable(dir_q) && $stable(mask_q)
             && $stable(pol_q) && $stable(edge_q) && $stable(byp_q)));

    // R11
    done_after_access_chk: assert property (@(posedge pclk) disable iff (!presetn)
        (state_q == BUS_DONE) |-> $past(psel && penable));
endmodule

// File: rtl/gpio_irq_gen.sv
module gpio_irq_gen #(
    parameter int          NUM_LINES = 32,
    parameter logic [31:0] IRQ_LINES = 32'hFFFF_FFFF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] smp,
    input  logic [NUM_LINES-1:0] mask_q,
    input  logic [NUM_LINES-1:0] pol_q,
    input  logic [NUM_LINES-1:0] edge_q,
    output logic [NUM_LINES-1:0] irq
);
    logic [NUM_LINES-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= smp;
    end

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        if (IRQ_LINES[i]) begin : g_cap
            logic hit;
            always_comb begin
                if (edge_q[i]) hit = pol_q[i] ? (smp[i] & ~prev_q[i]) : (~smp[i] & prev_q[i]);
                else           hit = pol_q[i] ? smp[i] : ~smp[i];
            end
            assign irq[i] = mask_q[i] & hit;

            // R8
            edge_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (irq[i] && edge_q[i] && $past(edge_q[i]) && $stable(pol_q[i]))
                |-> !$past(irq[i]));

            // R7
            level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(irq[i]) && !edge_q[i] && !$past(edge_q[i]) && $stable(smp[i])
                 && $stable(mask_q[i]) && $stable(pol_q[i]))
                |-> irq[i]);
        end else begin : g_none
            assign irq[i] = 1'b0;
        end
    end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port #(
    parameter int          NUM_LINES = 32,
    parameter logic [31:0] IRQ_LINES = 32'hFFFF_FFFF
) (
    input  logic                 pclk,
    input  logic                 presetn,
    input  logic                 psel,
    input  logic                 penable,
    input  logic                 pwrite,
    input  logic [2:0]           paddr,
    input  logic [31:0]          pwdata,
    output logic [31:0]          prdata,
    input  logic [NUM_LINES-1:0] pin_in,
    input  logic [NUM_LINES-1:0] alt_out,
    input  logic [NUM_LINES-1:0] alt_oe,
    output logic [NUM_LINES-1:0] pin_out,
    output logic [NUM_LINES-1:0] pin_oe,
    output logic [NUM_LINES-1:0] irq
);
    logic [NUM_LINES-1:0] smp;
    logic [NUM_LINES-1:0] out_q, dir_q, mask_q, pol_q, edge_q, byp_q;

    gpio_sync #(.WIDTH(NUM_LINES)) u_sync (
        .clk    (pclk),
        .rst_n  (presetn),
        .raw_in (pin_in),
        .synced (smp)
    );

    gpio_regfile #(.NUM_LINES(NUM_LINES), .IRQ_LINES(IRQ_LINES)) u_regs (
        .pclk    (pclk),
        .presetn (presetn),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .pwdata  (pwdata),
        .prdata  (prdata),
        .data_in (smp),
        .out_q   (out_q),
        .dir_q   (dir_q),
        .mask_q  (mask_q),
        .pol_q   (pol_q),
        .edge_q  (edge_q),
        .byp_q   (byp_q)
    );

    gpio_irq_gen #(.NUM_LINES(NUM_LINES), .IRQ_LINES(IRQ_LINES)) u_irq (
        .clk    (pclk),
        .rst_n  (presetn),
        .smp    (smp),
        .mask_q (mask_q),
        .pol_q  (pol_q),
        .edge_q (edge_q),
        .irq    (irq)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_pad
        assign pin_out[i] = byp_q[i] ? alt_out[i] : out_q[i];
        assign pin_oe[i]  = byp_q[i] ? alt_oe[i]  : dir_q[i];
    end
endmodule

// File: tb/gpio_irq_port_tb_top.sv
module gpio_irq_port_tb_top;
    localparam int          NL  = 12;
    localparam logic [31:0] CAP = 32'h0000_0F3E;

    logic          pclk = 1'b0;
    logic          presetn = 1'b0;
    logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [2:0]    paddr = '0;
    logic [31:0]   pwdata = '0;
    logic [31:0]   prdata;
    logic [NL-1:0] pin_in = '0, alt_out = '0, alt_oe = '0;
    logic [NL-1:0] pin_out, pin_oe, irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit r9_watch = 1'b0;

    always #5 pclk = ~pclk;

    gpio_irq_port #(.NUM_LINES(NL), .IRQ_LINES(CAP)) dut_i (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pin_in(pin_in), .alt_out(alt_out), .alt_oe(alt_oe),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    // Behavioural model state
    logic [NL-1:0] m_out = '0, m_dir = '0, m_mask = '0, m_pol = '0, m_edge = '0, m_byp = '0;
    logic [NL-1:0] hist[$] = '{12'h0, 12'h0, 12'h0};

    always @(posedge pclk) begin
        if (!presetn) hist = '{12'h0, 12'h0, 12'h0};
        else begin
            hist.push_front(pin_in);
            void'(hist.pop_back());
        end
    end

    function automatic logic [NL-1:0] exp_irq();
        logic [NL-1:0] r = '0;
        for (int i = 0; i < NL; i++) begin
            bit s = hist[1][i];
            bit p = hist[2][i];
            bit hit;
            if (m_edge[i]) hit = m_pol[i] ? (s && !p) : (!s && p);
            else           hit = m_pol[i] ? s : !s;
            r[i] = CAP[i] && m_mask[i] && hit;
        end
        return r;
    endfunction

    function automatic logic [31:0] exp_read(int ofs);
        logic [31:0] r = '0;
        case (ofs)
            0: r[NL-1:0] = hist[1];
            1: r[NL-1:0] = m_out;
            2: r[NL-1:0] = m_dir;
            3: r[NL-1:0] = m_mask;
            4: r[NL-1:0] = m_pol;
            5: r[NL-1:0] = m_edge;
            6: r[NL-1:0] = m_byp;
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison of pins and interrupts (R1 R3 R7 R8 R9 R10)
    always @(negedge pclk) begin
        if (!done) begin
            logic [NL-1:0] e_oe, e_out, e_irq;
            e_oe  = (m_byp & alt_oe)  | (~m_byp & m_dir);
            e_out = (m_byp & alt_out) | (~m_byp & m_out);
            e_irq = exp_irq();
            chk({pin_out, pin_oe, irq} === {e_out, e_oe, e_irq},
                "R1/R3/R7/R8/R10 pins+irq", {pin_out, pin_oe, irq}, {e_out, e_oe, e_irq});
            if (r9_watch) chk(irq === '0, "R9 masked irq", irq, 0);
        end
    end

    task automatic bus_write(int ofs, logic [31:0] d);
        @(posedge pclk); #1;
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = 3'(ofs); pwdata = d;
        @(posedge pclk); #1;
        penable = 1'b1;
        @(posedge pclk); #1;
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        case (ofs)
            1: m_out  = d[NL-1:0];
            2: m_dir  = d[NL-1:0];
            3: m_mask = d[NL-1:0];
            4: m_pol  = d[NL-1:0] & CAP[NL-1:0];
            5: m_edge = d[NL-1:0];
            6: m_byp  = d[NL-1:0];
            default: ;
        endcase
    endtask

    task automatic bus_read_chk(int ofs, string req);
        @(posedge pclk); #1;
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = 3'(ofs);
        @(posedge pclk); #1;
        penable = 1'b1;
        @(negedge pclk);
        chk(prdata === exp_read(ofs), req, prdata, exp_read(ofs));
        @(posedge pclk); #1;
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic run_pins(int n, logic [NL-1:0] seed);
        logic [NL-1:0] v = seed;
        for (int k = 0; k < n; k++) begin
            @(posedge pclk); #1;
            pin_in = v;
            v = {v[NL-2:0], v[NL-1] ^ v[5] ^ v[3] ^ v[0]};
            if (k % 3 == 2) v = v ^ 12'h021;
        end
    endtask

    initial begin
        #1_000_000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge pclk);
        #1 presetn = 1'b1;

        // R1 reset values, R2 unused offset
        for (int o = 0; o < 8; o++) bus_read_chk(o, "R1 R2 reset readback");

        // R4 output bits above the line count
        bus_write(1, 32'hFFFF_FFFF);
        bus_read_chk(1, "R4 output width");
        // R5 polarity writable only on capable lines
        bus_write(4, 32'hFFFF_FFFF);
        bus_read_chk(4, "R5 polarity capability");
        bus_write(4, 32'h0);

        // R2 R3 direction and output
        bus_write(2, 32'h0F0);
        bus_write(1, 32'h0A5);
        bus_read_chk(2, "R2 direction readback");
        bus_read_chk(1, "R2 output readback");

        // R6 synchronised data
        @(posedge pclk); #1 pin_in = 12'h5A3;
        repeat (3) @(posedge pclk);
        bus_read_chk(0, "R6 data sample");
        @(posedge pclk); #1 pin_in = 12'hC3C;
        @(posedge pclk);
        bus_read_chk(0, "R6 data after change");

        // R7 level mode
        bus_write(3, 32'hFFF);
        bus_write(4, 32'h0F0);
        run_pins(24, 12'h3A5);
        // R8 edge mode
        bus_write(5, 32'hFFF);
        bus_write(4, 32'h3C6);
        run_pins(40, 12'h1F3);
        // R9 mask suppression
        bus_write(3, 32'h0);
        @(posedge pclk); #1 r9_watch = 1'b1;
        run_pins(20, 12'h6B1);
        bus_write(5, 32'h0);
        run_pins(10, 12'h0F0);
        @(posedge pclk); #1 r9_watch = 1'b0;

        // R10 bypass
        bus_write(2, 32'hFF0);
        alt_out = 12'hA5A; alt_oe = 12'h3C3;
        bus_write(6, 32'h00F);
        for (int k = 0; k < 6; k++) begin
            @(posedge pclk); #1;
            alt_out = ~alt_out ^ 12'(k); alt_oe = alt_oe ^ 12'h0F5;
        end
        bus_read_chk(6, "R10 bypass readback");

        // R11 enable without setup phase
        @(posedge pclk); #1;
        psel = 1'b1; penable = 1'b1; pwrite = 1'b1; paddr = 3'd2; pwdata = 32'h0;
        @(posedge pclk); #1;
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        bus_read_chk(2, "R11 naked enable ignored");
        // R11 transfer with select low
        @(posedge pclk); #1;
        psel = 1'b0; penable = 1'b0; pwrite = 1'b1; paddr = 3'd1; pwdata = 32'hFFF;
        @(posedge pclk); #1 penable = 1'b1;
        @(posedge pclk); #1 penable = 1'b0; pwrite = 1'b0;
        bus_read_chk(1, "R11 unselected write ignored");

        repeat (2) @(posedge pclk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule